// File: doc/BRIEF.md
# Trace Scoreboard Eviction Guard

This block keeps a two-dimensional grid of small reference counters that tells cache replacement logic which lines are safe to evict. Each row of the grid belongs to one cacheline and each column to one speculative execution trace that is still pending. An instruction issued from a line under a trace raises the count in that cell. Retiring the instruction lowers it again.

When a trace is dropped because its predicate resolved false, its whole column is cleared in one cycle. Every reference that trace held disappears at once, and no per-instruction cleanup is needed. A line is reported as evictable only while every cell in its row is zero, which means no trace still refers to it.

Line and trace numbers on the event inputs are plain binary indices. Bit i of the eviction vector belongs to line i. The counters are narrow and saturating. Two sticky-free pulse flags report an issue that hit a full counter and a retire that hit an empty one.

Top module: `trace_scoreboard`

## Requirements
- R1: A synchronous active-high reset clears every counter. In the cycle after reset all bits of `evict_ok` are 1, and `sat_flag` and `underflow_err` are 0.
- R2: An issue event (line L, trace T) adds one to cell (L,T). Bit L of `evict_ok` is 0 from the next cycle on.
- R3: A retire event (line L, trace T) takes one from cell (L,T). Once the row is all zero, bit L of `evict_ok` returns to 1.
- R4: Bit L of `evict_ok` is 1 only when the counts of line L under every trace are zero. A line held by two traces stays blocked until both have retired.
- R5: A squash of trace T sets all cells of column T to zero in a single cycle. Counts held under other traces are kept.
- R6: A squash of trace T wins over an issue or retire aimed at column T in the same cycle. The issue or retire is dropped and raises no flag.
- R7: Each counter is 4 bits wide and stops at 15. An issue to a cell already at 15 leaves it at 15 and makes `sat_flag` 1 for one cycle, in the cycle after that issue.
- R8: A retire to a cell at zero leaves it at zero and makes `underflow_err` 1 for one cycle, in the cycle after that retire.
- R9: An issue and a retire aimed at the same cell in the same cycle leave that cell unchanged and raise no flag.
- R10: An issue and a retire aimed at different cells in the same cycle are both applied.
- R11: `evict_ok` depends only on the stored counts. It does not change before the clock edge that takes in an event, and it shows the event's effect right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | Issue event valid |
| iss_line | input | LINE_W | Line index of the issued instruction |
| iss_trace | input | TRACE_W | Trace index of the issued instruction |
| ret_vld | input | 1 | Retire event valid |
| ret_line | input | LINE_W | Line index of the retired instruction |
| ret_trace | input | TRACE_W | Trace index of the retired instruction |
| sq_vld | input | 1 | Trace squash valid |
| sq_trace | input | TRACE_W | Trace to drop |
| evict_ok | output | NUM_LINES | Per-line evict-allowed vector |
| sat_flag | output | 1 | Pulse: an issue hit a full counter |
| underflow_err | output | 1 | Pulse: a retire hit an empty counter |

## Verification
Issue, retire and squash can all arrive in one cycle, and their interaction is the risky part. The vector table pairs an issue with a retire on the same cell and on different cells. It also pairs a squash with an issue and with a retire aimed at the squashed column. The outcome is judged one cycle later from `evict_ok` and from the two flags. Because a hidden count cannot be read directly, it is measured by retiring one step at a time until the line's eviction bit returns. The number of retires needed exposes a wrapped or lost count.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam int unsigned DEF_LINES  = 8;
  localparam int unsigned DEF_TRACES = 4;
  localparam int unsigned DEF_CNT_W  = 4;

  // flat position of cell (line, trace) in the counter grid
  function automatic int unsigned cell_idx(input int unsigned line,
                                           input int unsigned trace,
                                           input int unsigned traces);
    return line * traces + trace;
  endfunction
endpackage

// File: rtl/tsb_event_decode.sv
module tsb_event_decode
  import tsb_pkg::*;
#(
  parameter int unsigned NUM_LINES  = DEF_LINES,
  parameter int unsigned NUM_TRACES = DEF_TRACES,
  parameter int unsigned LINE_W     = $clog2(NUM_LINES),
  parameter int unsigned TRACE_W    = $clog2(NUM_TRACES),
  localparam int unsigned CELLS     = NUM_LINES * NUM_TRACES
) (
  input  logic               iss_vld,
  input  logic [LINE_W-1:0]  iss_line,
  input  logic [TRACE_W-1:0] iss_trace,
  input  logic               ret_vld,
  input  logic [LINE_W-1:0]  ret_line,
  input  logic [TRACE_W-1:0] ret_trace,
  input  logic               sq_vld,
  input  logic [TRACE_W-1:0] sq_trace,
  output logic [CELLS-1:0]   inc_vec,
  output logic [CELLS-1:0]   dec_vec,
  output logic [CELLS-1:0]   clr_vec
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    for (genvar t = 0; t < NUM_TRACES; t++) begin : g_trace
      localparam int unsigned IDX = cell_idx(l, t, NUM_TRACES);
      assign inc_vec[IDX] = iss_vld && (iss_line == LINE_W'(l)) && (iss_trace == TRACE_W'(t));
      assign dec_vec[IDX] = ret_vld && (ret_line == LINE_W'(l)) && (ret_trace == TRACE_W'(t));
      assign clr_vec[IDX] = sq_vld && (sq_trace == TRACE_W'(t));
    end
  end
endmodule

// File: rtl/tsb_cell.sv
module tsb_cell
  import tsb_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  input  logic clr,
  output logic is_zero,
  output logic sat_hit,
  output logic uf_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             inc_only, dec_only;

  // squash dominates; a paired issue/retire cancels out
  assign inc_only = inc && !dec && !clr;
  assign dec_only = dec && !inc && !clr;
  assign sat_hit  = inc_only && (cnt == CNT_MAX);
  assign uf_hit   = dec_only && (cnt == '0);
  assign is_zero  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                                 cnt <= '0;
    else if (clr)                            cnt <= '0;
    else if (inc_only && cnt != CNT_MAX)     cnt <= cnt + 1'b1;
    else if (dec_only && cnt != '0)          cnt <= cnt - 1'b1;
  end

  assert_inc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (inc_only && cnt != CNT_MAX) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_dec_step_R3: assert property (@(posedge clk) disable iff (rst)
    (dec_only && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  assert_col_clear_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && !clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && !clr && cnt == '0) |=> (cnt == '0));

  assert_pair_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (inc && dec && !clr) |=> $stable(cnt));
endmodule

// File: rtl/tsb_row_guard.sv
module tsb_row_guard
  import tsb_pkg::*;
#(
  parameter int unsigned NUM_LINES  = DEF_LINES,
  parameter int unsigned NUM_TRACES = DEF_TRACES,
  localparam int unsigned CELLS     = NUM_LINES * NUM_TRACES
) (
  input  logic [CELLS-1:0]     cell_zero,
  output logic [NUM_LINES-1:0] evict_ok
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_row
    assign evict_ok[l] = &cell_zero[l*NUM_TRACES +: NUM_TRACES];
  end
endmodule

// File: rtl/trace_scoreboard.sv
module trace_scoreboard
  import tsb_pkg::*;
#(
  parameter int unsigned NUM_LINES  = DEF_LINES,
  parameter int unsigned NUM_TRACES = DEF_TRACES,
  parameter int unsigned CNT_W      = DEF_CNT_W,
  localparam int unsigned LINE_W    = (NUM_LINES  > 1) ? $clog2(NUM_LINES)  : 1,
  localparam int unsigned TRACE_W   = (NUM_TRACES > 1) ? $clog2(NUM_TRACES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 iss_vld,
  input  logic [LINE_W-1:0]    iss_line,
  input  logic [TRACE_W-1:0]   iss_trace,
  input  logic                 ret_vld,
  input  logic [LINE_W-1:0]    ret_line,
  input  logic [TRACE_W-1:0]   ret_trace,
  input  logic                 sq_vld,
  input  logic [TRACE_W-1:0]   sq_trace,
  output logic [NUM_LINES-1:0] evict_ok,
  output logic                 sat_flag,
  output logic                 underflow_err
);
  localparam int unsigned CELLS = NUM_LINES * NUM_TRACES;

  logic [CELLS-1:0] inc_vec, dec_vec, clr_vec;
  logic [CELLS-1:0] zero_vec, sat_vec, uf_vec;

  tsb_event_decode #(
    .NUM_LINES (NUM_LINES),
    .NUM_TRACES(NUM_TRACES),
    .LINE_W    (LINE_W),
    .TRACE_W   (TRACE_W)
  ) decode_i (
    .iss_vld  (iss_vld),
    .iss_line (iss_line),
    .iss_trace(iss_trace),
    .ret_vld  (ret_vld),
    .ret_line (ret_line),
    .ret_trace(ret_trace),
    .sq_vld   (sq_vld),
    .sq_trace (sq_trace),
    .inc_vec  (inc_vec),
    .dec_vec  (dec_vec),
    .clr_vec  (clr_vec)
  );

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    tsb_cell #(.CNT_W(CNT_W)) cell_i (
      .clk    (clk),
      .rst    (rst),
      .inc    (inc_vec[c]),
      .dec    (dec_vec[c]),
      .clr    (clr_vec[c]),
      .is_zero(zero_vec[c]),
      .sat_hit(sat_vec[c]),
      .uf_hit (uf_vec[c])
    );
  end

  tsb_row_guard #(
    .NUM_LINES (NUM_LINES),
    .NUM_TRACES(NUM_TRACES)
  ) guard_i (
    .cell_zero(zero_vec),
    .evict_ok (evict_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sat_flag      <= 1'b0;
      underflow_err <= 1'b0;
    end else begin
      sat_flag      <= |sat_vec;
      underflow_err <= |uf_vec;
    end
  end

  assert_issue_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    (iss_vld && !(sq_vld && sq_trace == iss_trace)
     && !(ret_vld && ret_line == iss_line && ret_trace == iss_trace))
    |=> !evict_ok[$past(iss_line)]);

  assert_squash_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (sq_vld && !(iss_vld && iss_trace != sq_trace) && !(ret_vld && ret_trace != sq_trace))
    |=> (!sat_flag && !underflow_err));
endmodule

// File: tb/trace_scoreboard_tb_top.sv
`timescale 1ns/1ps
module trace_scoreboard_tb_top;
  localparam int unsigned LINES  = 8;
  localparam int unsigned TRACES = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       iss_vld = 1'b0, ret_vld = 1'b0, sq_vld = 1'b0;
  logic [2:0] iss_line = '0, ret_line = '0;
  logic [1:0] iss_trace = '0, ret_trace = '0, sq_trace = '0;
  logic [7:0] evict_ok;
  logic       sat_flag, underflow_err;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  trace_scoreboard #(.NUM_LINES(LINES), .NUM_TRACES(TRACES), .CNT_W(4)) dut_i (
    .clk(clk), .rst(rst),
    .iss_vld(iss_vld), .iss_line(iss_line), .iss_trace(iss_trace),
    .ret_vld(ret_vld), .ret_line(ret_line), .ret_trace(ret_trace),
    .sq_vld(sq_vld), .sq_trace(sq_trace),
    .evict_ok(evict_ok), .sat_flag(sat_flag), .underflow_err(underflow_err)
  );

  typedef struct packed {
    logic       iv; logic [2:0] il; logic [1:0] it;
    logic       rv; logic [2:0] rl; logic [1:0] rt;
    logic       sv; logic [1:0] st;
    logic [7:0] ev; logic sat; logic err;
  } vec_t;

  // iv il it | rv rl rt | sv st | expected evict, sat, err
  localparam vec_t VEC [0:17] = '{
    '{1'b1,3'd0,2'd0, 1'b0,3'd0,2'd0, 1'b0,2'd0, 8'hFE,1'b0,1'b0}, // R2
    '{1'b1,3'd0,2'd1, 1'b0,3'd0,2'd0, 1'b0,2'd0, 8'hFE,1'b0,1'b0}, // R4
    '{1'b0,3'd0,2'd0, 1'b1,3'd0,2'd0, 1'b0,2'd0, 8'hFE,1'b0,1'b0}, // R4 still held by T1
    '{1'b0,3'd0,2'd0, 1'b1,3'd0,2'd1, 1'b0,2'd0, 8'hFF,1'b0,1'b0}, // R3
    '{1'b1,3'd2,2'd1, 1'b0,3'd0,2'd0, 1'b0,2'd0, 8'hFB,1'b0,1'b0}, // R2
    '{1'b1,3'd3,2'd2, 1'b0,3'd0,2'd0, 1'b0,2'd0, 8'hF3,1'b0,1'b0}, // R2
    '{1'b0,3'd0,2'd0, 1'b0,3'd0,2'd0, 1'b1,2'd1, 8'hF7,1'b0,1'b0}, // R5
    '{1'b1,3'd5,2'd2, 1'b0,3'd0,2'd0, 1'b1,2'd2, 8'hFF,1'b0,1'b0}, // R6 issue dropped
    '{1'b1,3'd4,2'd3, 1'b0,3'd0,2'd0, 1'b0,2'd0, 8'hEF,1'b0,1'b0}, // R2
    '{1'b1,3'd4,2'd3, 1'b1,3'd4,2'd3, 1'b0,2'd0, 8'hEF,1'b0,1'b0}, // R9
    '{1'b0,3'd0,2'd0, 1'b1,3'd4,2'd3, 1'b0,2'd0, 8'hFF,1'b0,1'b0}, // R9 count was 1
    '{1'b0,3'd0,2'd0, 1'b1,3'd4,2'd3, 1'b0,2'd0, 8'hFF,1'b0,1'b1}, // R8
    '{1'b1,3'd1,2'd0, 1'b0,3'd0,2'd0, 1'b0,2'd0, 8'hFD,1'b0,1'b0}, // R2
    '{1'b1,3'd6,2'd3, 1'b1,3'd1,2'd0, 1'b0,2'd0, 8'hBF,1'b0,1'b0}, // R10
    '{1'b0,3'd0,2'd0, 1'b0,3'd0,2'd0, 1'b1,2'd3, 8'hFF,1'b0,1'b0}, // R5
    '{1'b1,3'd0,2'd1, 1'b0,3'd0,2'd0, 1'b0,2'd0, 8'hFE,1'b0,1'b0}, // R2
    '{1'b0,3'd0,2'd0, 1'b1,3'd0,2'd1, 1'b1,2'd1, 8'hFF,1'b0,1'b0}, // R6 retire dropped
    '{1'b0,3'd0,2'd0, 1'b1,3'd0,2'd1, 1'b0,2'd0, 8'hFF,1'b0,1'b1}  // R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    iss_vld = 1'b0; ret_vld = 1'b0; sq_vld = 1'b0;
  endtask

  task automatic issue(input logic [2:0] l, input logic [1:0] t);
    idle(); iss_vld = 1'b1; iss_line = l; iss_trace = t;
  endtask

  task automatic retire(input logic [2:0] l, input logic [1:0] t);
    idle(); ret_vld = 1'b1; ret_line = l; ret_trace = t;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 evict after reset", 32'(evict_ok), 32'hFF);
    check("R1 sat after reset", 32'(sat_flag), 32'h0);
    check("R1 err after reset", 32'(underflow_err), 32'h0);

    for (int i = 0; i < 18; i++) begin
      iss_vld = VEC[i].iv; iss_line = VEC[i].il; iss_trace = VEC[i].it;
      ret_vld = VEC[i].rv; ret_line = VEC[i].rl; ret_trace = VEC[i].rt;
      sq_vld  = VEC[i].sv; sq_trace = VEC[i].st;
      @(negedge clk);
      check($sformatf("vec%0d evict", i), 32'(evict_ok), 32'(VEC[i].ev));
      check($sformatf("vec%0d sat R7", i), 32'(sat_flag), 32'(VEC[i].sat));
      check($sformatf("vec%0d err R8", i), 32'(underflow_err), 32'(VEC[i].err));
    end
    idle();

    // R7: saturation at 15, no wrap
    for (int k = 1; k <= 16; k++) begin
      issue(3'd7, 2'd0);
      @(negedge clk);
      if (k >= 15) check($sformatf("R7 sat after issue %0d", k), 32'(sat_flag), 32'(k == 16));
    end
    idle();
    @(negedge clk);
    check("R7 sat pulse ends", 32'(sat_flag), 32'h0);
    for (int k = 1; k <= 15; k++) begin
      retire(3'd7, 2'd0);
      @(negedge clk);
      if (k >= 14) check($sformatf("R7 line7 evict after retire %0d", k), 32'(evict_ok[7]), 32'(k == 15));
    end
    check("R7 no underflow on drain", 32'(underflow_err), 32'h0);
    idle();

    // R11: output moves only at the edge
    issue(3'd2, 2'd0);
    #1;
    check("R11 evict before edge", 32'(evict_ok), 32'hFF);
    @(negedge clk);
    check("R11 evict after edge", 32'(evict_ok), 32'hFB);
    retire(3'd2, 2'd0);
    @(negedge clk);
    idle();

    // R1: reset mid-run clears counts
    issue(3'd5, 2'd1);
    @(negedge clk);
    check("R1 pre-reset hold", 32'(evict_ok), 32'hDF);
    idle(); rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 evict after mid reset", 32'(evict_ok), 32'hFF);
    retire(3'd5, 2'd1);
    @(negedge clk);
    check("R1 cell cleared by reset", 32'(underflow_err), 32'h1);
    idle();
    @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule